// File: doc/BRIEF.md
# SYSREF Pulse Generator

This block derives a slow, phase-controlled timing strobe from a fast reference clock. A two-stage counting chain sets the shape of the strobe: a small pre-scaler followed by a wide main divider. The main divider's count is split into a high part and a low part.

Three operating modes choose what reaches the single output:
- **Continuous:** the free-running divided waveform.
- **Burst:** a programmed number of whole divider periods, started by an external request.
- **Repeater:** one short pulse for each request edge.

The request pin is asynchronous to the reference clock. It is resynchronised, and only its rising edges are used. A clear control can hold the internal request low, except in repeater mode. A subsystem enable forces the whole block quiet and resets it. A bypass flag stands in for an external delay path. While the bypass flag is set, odd division ratios are legal.

The block sits between the software-visible configuration (mode, counts, ratios) and the strobe distribution network. All configuration inputs are treated as quasi-static.

Top module: `sysref_pulse_gen`

## Requirements
- R1: With `mode` = 0 (continuous), `sysref_out` repeats with a period of Deff*P reference cycles and stays high for H*P cycles of each period. Here P = `pre_div`+1, Deff is the effective ratio defined in R6, and H = floor(Deff/2).
- R2: With `mode` = 1 (burst), each accepted rising request edge produces exactly N high pulses on `sysref_out` and then the output stays low. N is `pulse_cnt`, and a `pulse_cnt` of 0 means N = 16.
- R3: Pulse shape and latency in burst mode:
  - Each burst pulse is high for H*P cycles, and pulses start Deff*P cycles apart.
  - Call the first rising clock edge that sees `req_in` high the sampling edge. The first pulse goes high at the third edge after the sampling edge.
- R4: A request edge that arrives while a burst is still running is ignored. That burst emits its N pulses unchanged, and a later request starts a full new burst.
- R5: With `mode` = 2 (repeater), each rising request edge yields exactly one `sysref_out` pulse, one cycle wide. It goes high at the second edge after the sampling edge, and `pulse_cnt` has no effect.
- R6: The effective ratio Deff is set from `main_div` as follows:
  - A `main_div` of 0 or 1 gives Deff = 2.
  - An odd `main_div` is used as-is only when `dly_bypass` = 1; otherwise Deff = `main_div`+1.
  - An even `main_div` is used as-is.
- R7: The pre-scaler divides the reference clock by `pre_div`+1 (1 to 4) ahead of the main divider.
- R8: While `req_clr` is 1, request edges start nothing in burst mode. In repeater mode `req_clr` is ignored.
- R9: While `enable` is 0, `sysref_out` is low from the next edge on. An interrupted burst is abandoned, and after re-enable a new request gives a complete burst.
- R10: With `mode` = 3, `sysref_out` stays low whatever the request input does.
- R11: A synchronous active-high `rst` drives `sysref_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Subsystem enable; 0 holds output low and counters cleared |
| mode | input | 2 | 0 continuous, 1 burst, 2 repeater, 3 off |
| pulse_cnt | input | 4 | Pulses per burst (0 means 16) |
| pre_div | input | 2 | Pre-scaler ratio minus one |
| main_div | input | 12 | Main divider ratio |
| dly_bypass | input | 1 | Delay-path bypass; permits odd ratios |
| req_clr | input | 1 | Holds internal request low (not in repeater mode) |
| req_in | input | 1 | Asynchronous request input |
| sysref_out | output | 1 | Registered timing strobe |

## Verification
The bench targets the following corner cases and the way a faulty design would show each one:
- **Odd ratios with and without bypass.** A design that ignores the flag shows the wrong period on one of the two runs.
- **Ratios of 0 and 1.** A design that does not clamp these would stall or emit a constant level.
- **A pulse count of 0.** This must give 16 pulses; a naive counter would give none, or run forever.
- **A second request inside a running burst.** A design that re-arms would give extra pulses.
- **The clear control.** It must block bursts but not repeats.
- **Enable dropped mid-burst.** A stale burst counter would show as a short or extra burst after re-enable.

// File: rtl/sysref_pkg.sv
package sysref_pkg;
  typedef enum logic [1:0] {
    MODE_CONT   = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_REPEAT = 2'd2,
    MODE_OFF    = 2'd3
  } sr_mode_e;
endpackage

// File: rtl/sr_req_sync.sv
// Request synchroniser, clear gating and rising-edge detector.
module sr_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic req_in,
  input  logic clr,
  input  logic clr_ignore,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              gated;
  logic              gated_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) sync_q <= '0;
    else                sync_q <= {sync_q[STAGES-2:0], req_in};
  end

  assign gated = sync_q[STAGES-1] & (clr_ignore | ~clr);

  always_ff @(posedge clk) begin
    if (rst || !enable) gated_q <= 1'b0;
    else                gated_q <= gated;
  end

  assign rise = gated & ~gated_q;

  // R5
  single_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && enable) |=> !rise);
endmodule

// File: rtl/sr_div_chain.sv
// Pre-scaler followed by main divider; produces the high phase and the wrap strobe.
module sr_div_chain #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [DIV_W-1:0] main_div,
  input  logic             bypass,
  output logic             hi,
  output logic             wrap
);
  localparam int EFF_W = DIV_W + 1;

  logic [PRE_W-1:0] pcnt;
  logic [EFF_W-1:0] dcnt;
  logic [EFF_W-1:0] eff;
  logic             tick;
  logic             at_end;

  always_comb begin
    if (main_div < DIV_W'(2))
      eff = EFF_W'(2);
    else if (main_div[0] && !bypass)
      eff = {1'b0, main_div} + EFF_W'(1);
    else
      eff = {1'b0, main_div};
  end

  assign tick   = (pcnt >= pre_div);
  assign at_end = (dcnt >= eff - EFF_W'(1));
  assign wrap   = tick & at_end;
  assign hi     = (dcnt < (eff >> 1));

  always_ff @(posedge clk) begin
    if (rst || !enable || restart) pcnt <= '0;
    else if (tick)                 pcnt <= '0;
    else                           pcnt <= pcnt + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable || restart) dcnt <= '0;
    else if (tick)                 dcnt <= at_end ? '0 : dcnt + EFF_W'(1);
  end

  // R6
  wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |-> !hi);
endmodule

// File: rtl/sr_burst_ctrl.sv
// Pulse counter gating the divider in burst mode.
module sr_burst_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             burst_mode,
  input  logic             rise,
  input  logic             wrap,
  input  logic [CNT_W-1:0] pulse_cnt,
  output logic             start,
  output logic             active
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] remaining;
  logic [CNT_W:0] load;

  assign load  = (pulse_cnt == '0) ? FULL : {1'b0, pulse_cnt};
  assign start = burst_mode & rise & ~active;

  always_ff @(posedge clk) begin
    if (rst || !enable || !burst_mode) begin
      active    <= 1'b0;
      remaining <= '0;
    end else if (start) begin
      active    <= 1'b1;
      remaining <= load;
    end else if (active && wrap) begin
      if (remaining == (CNT_W+1)'(1)) active <= 1'b0;
      remaining <= remaining - (CNT_W+1)'(1);
    end
  end

  // R2
  count_live_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (remaining != '0 && remaining <= FULL));

  // R4
  arm_only_on_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(rise));
endmodule

// File: rtl/sysref_pulse_gen.sv
module sysref_pulse_gen
  import sysref_pkg::*;
#(
  parameter int PRE_W       = 2,
  parameter int DIV_W       = 12,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] pulse_cnt,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [DIV_W-1:0] main_div,
  input  logic             dly_bypass,
  input  logic             req_clr,
  input  logic             req_in,
  output logic             sysref_out
);
  sr_mode_e md;
  logic     rep_mode;
  logic     burst_mode;
  logic     rise;
  logic     start;
  logic     active;
  logic     hi;
  logic     wrap;
  logic     out_d;

  assign md         = sr_mode_e'(mode);
  assign rep_mode   = (md == MODE_REPEAT);
  assign burst_mode = (md == MODE_BURST);

  sr_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .req_in     (req_in),
    .clr        (req_clr),
    .clr_ignore (rep_mode),
    .rise       (rise)
  );

  sr_div_chain #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .restart  (start),
    .pre_div  (pre_div),
    .main_div (main_div),
    .bypass   (dly_bypass),
    .hi       (hi),
    .wrap     (wrap)
  );

  sr_burst_ctrl #(.CNT_W(CNT_W)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .burst_mode (burst_mode),
    .rise       (rise),
    .wrap       (wrap),
    .pulse_cnt  (pulse_cnt),
    .start      (start),
    .active     (active)
  );

  always_comb begin
    unique case (md)
      MODE_CONT:   out_d = hi;
      MODE_BURST:  out_d = active & hi;
      MODE_REPEAT: out_d = rise;
      default:     out_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) sysref_out <= 1'b0;
    else                sysref_out <= out_d;
  end

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sysref_out);

  // R10
  off_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (md == MODE_OFF) |=> !sysref_out);

  // R5
  repeat_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (sysref_out && md == MODE_REPEAT && $past(md) == MODE_REPEAT)
      |=> !sysref_out);
endmodule

// File: tb/sysref_pulse_gen_tb.sv
module sysref_pulse_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  pulse_cnt = 4'd1;
  logic [1:0]  pre_div = 2'd2;
  logic [11:0] main_div = 12'h020;
  logic        dly_bypass = 1'b0;
  logic        req_clr = 1'b0;
  logic        req_in = 1'b0;
  logic        sysref_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysref_pulse_gen u_dut (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode),
    .pulse_cnt(pulse_cnt), .pre_div(pre_div), .main_div(main_div),
    .dly_bypass(dly_bypass), .req_clr(req_clr), .req_in(req_in),
    .sysref_out(sysref_out)
  );

  typedef struct packed {
    logic [1:0]  pre;
    logic [11:0] dv;
    logic        byp;
    logic [3:0]  n;
    logic [7:0]  pulses;
    logic [7:0]  high;
    logic [7:0]  period;
  } vec_t;

  // Burst vectors: expected pulses, total high cycles, rise-to-rise spacing
  localparam vec_t VECS [0:7] = '{
    '{2'd0, 12'd4,  1'b0, 4'd3, 8'd3,  8'd6,  8'd4},
    '{2'd1, 12'd6,  1'b0, 4'd2, 8'd2,  8'd12, 8'd12},
    '{2'd0, 12'd5,  1'b1, 4'd2, 8'd2,  8'd4,  8'd5},
    '{2'd0, 12'd5,  1'b0, 4'd2, 8'd2,  8'd6,  8'd6},
    '{2'd0, 12'd1,  1'b1, 4'd1, 8'd1,  8'd1,  8'd0},
    '{2'd3, 12'd3,  1'b1, 4'd4, 8'd4,  8'd16, 8'd12},
    '{2'd0, 12'd2,  1'b0, 4'd0, 8'd16, 8'd16, 8'd2},
    '{2'd2, 12'd32, 1'b0, 4'd1, 8'd1,  8'd48, 8'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Samples sysref_out at each falling edge for win cycles.
  task automatic measure(input int win, input int drop_at, input int rereq_at,
                         output int rises, output int highs, output int first,
                         output int period, output int maxw);
    int second;
    int run;
    logic prev;
    rises = 0; highs = 0; first = 0; second = 0; maxw = 0; run = 0; prev = 1'b0;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (sysref_out && !prev) begin
        rises++;
        if (first == 0) first = i;
        else if (second == 0) second = i;
      end
      if (sysref_out) begin
        highs++;
        run++;
        if (run > maxw) maxw = run;
      end else begin
        run = 0;
      end
      prev = sysref_out;
      if (i == drop_at) req_in = 1'b0;
      if (i == rereq_at) req_in = 1'b1;
      if (i == rereq_at + 3) req_in = 1'b0;
    end
    period = (second > 0) ? second - first : 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int r, h, f, p, w;
    // R11 reset
    idle(3);
    check("R11 out during reset", int'(sysref_out), 0);
    rst = 1'b0;
    idle(2);

    // Table walk: burst mode vectors (R2 R3 R6 R7)
    mode = 2'd1;
    for (int k = 0; k < 8; k++) begin
      pre_div    = VECS[k].pre;
      main_div   = VECS[k].dv;
      dly_bypass = VECS[k].byp;
      pulse_cnt  = VECS[k].n;
      idle(4);
      req_in = 1'b1;
      measure(120, 3, -10, r, h, f, p, w);
      check($sformatf("R2 pulses vec%0d", k), r, int'(VECS[k].pulses));
      check($sformatf("R3 R6 R7 high cycles vec%0d", k), h, int'(VECS[k].high));
      check($sformatf("R3 latency vec%0d", k), f, 4);
      if (VECS[k].pulses > 1)
        check($sformatf("R3 R6 R7 period vec%0d", k), p, int'(VECS[k].period));
    end

    // R4: second request inside a running burst is ignored
    pre_div = 2'd0; main_div = 12'd8; dly_bypass = 1'b0; pulse_cnt = 4'd2;
    idle(4);
    req_in = 1'b1;
    measure(60, 3, 8, r, h, f, p, w);
    check("R4 pulses with mid-burst request", r, 2);
    check("R4 high cycles with mid-burst request", h, 8);
    idle(4);
    req_in = 1'b1;
    measure(60, 3, -10, r, h, f, p, w);
    check("R4 later request gives full burst", r, 2);

    // R8: clear blocks bursts
    req_clr = 1'b1;
    pulse_cnt = 4'd5;
    idle(4);
    req_in = 1'b1;
    measure(80, 3, -10, r, h, f, p, w);
    check("R8 burst held by clear", r, 0);

    // R5 and R8: repeater ignores clear and pulse count
    mode = 2'd2;
    idle(4);
    req_in = 1'b1;
    measure(20, 3, -10, r, h, f, p, w);
    check("R5 repeater pulse count", r, 1);
    check("R5 repeater width", h, 1);
    check("R5 repeater latency", f, 3);
    req_clr = 1'b0;
    idle(4);

    // R1: continuous waveform, P=2, D=6
    mode = 2'd0; pre_div = 2'd1; main_div = 12'd6;
    idle(20);
    measure(60, -10, -10, r, h, f, p, w);
    check("R1 continuous period", p, 12);
    check("R1 continuous high width", w, 6);

    // R9: enable low silences continuous output
    enable = 1'b0;
    @(negedge clk);
    measure(20, -10, -10, r, h, f, p, w);
    check("R9 output low while disabled", h, 0);
    enable = 1'b1;

    // R9: burst interrupted by disable, then a fresh full burst
    mode = 2'd1; pre_div = 2'd0; main_div = 12'd4; pulse_cnt = 4'd3;
    idle(4);
    req_in = 1'b1;
    idle(3);
    req_in = 1'b0;
    idle(3);
    enable = 1'b0;
    @(negedge clk);
    measure(20, -10, -10, r, h, f, p, w);
    check("R9 burst abandoned when disabled", h, 0);
    enable = 1'b1;
    idle(4);
    req_in = 1'b1;
    measure(40, 3, -10, r, h, f, p, w);
    check("R9 full burst after re-enable", r, 3);

    // R10: mode 3 stays low
    mode = 2'd3;
    idle(4);
    req_in = 1'b1;
    measure(30, 3, -10, r, h, f, p, w);
    check("R10 off mode output", h, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule